// File: doc/BRIEF.md
# Delay-Line Tap Steering Controller

This block picks one of 128 positions on a delay line so that a clock looped back from the board lines up in phase with the chip's internal reference clock. A phase comparator outside the block reports whether the returned clock trails the reference (`cmp_lag`) or leads it (`cmp_lead`). The controller acts on that report once in every fixed evaluation interval of five clock cycles. Each time it acts, it moves the tap by at most one position.

Software uses a small register port. It writes two mode bits and then pulses a park bit high and back low. Parking forces the tap to position 12, and tracking starts from there once the park bit is released. The two mode values are captured at the moment of release and drive the delay line's range-extension and coarse-step controls until the next release. The current tap, a lock flag and a sticky out-of-range flag can be read back at any time.

Lock is reached when the tap dithers around the phase-match point, which shows up as two reversals of direction in a row. Lock is lost when the tap makes a run of three moves the same way.

Top module: `dll_tap_ctrl`

## Requirements
- R1: After hard reset, the tap is 12 and the lock flag, out-of-range flag, both mode outputs and the control register all read 0.
- R2: Until the first release of the park bit (a write to the control register that changes the park bit from 1 to 0), the tap stays at 12 whatever the comparator reports. A control write that leaves the park bit at 0 does not start tracking.
- R3: While the park bit is 1, the tap is forced to 12 one cycle later, the lock flag and the out-of-range flag are cleared, and the evaluation counter is held at zero.
- R4: After a release, evaluations happen on the 5th rising edge and then on every 5th edge after that. The tap changes only on those edges, and by at most one position each time.
- R5: At an evaluation, lag alone moves the tap up by one and lead alone moves it down by one. Both asserted, or neither asserted, leaves the tap unchanged.
- R6: The tap saturates at 127 and at 0. A request to step past either end leaves the tap unchanged and sets the out-of-range flag, which stays set until the next park.
- R7: The lock flag rises on the evaluation that completes a second consecutive direction reversal. Evaluations that request no move do not affect the lock history.
- R8: The lock flag falls on the evaluation that completes three consecutive requests in the same direction.
- R9: The mode bits reach `ext_range_o` and `coarse_step_o` only when the park bit is released, taking the values written in the releasing write. Writes made while tracking do not change these outputs.
- R10: The register map is as follows. Address 0 is control, read/write: bit 0 park, bit 1 range extension, bit 2 coarse step. Address 1 is the tap in bits 6:0, read-only. Address 2 is status, read-only: bit 0 lock, bit 1 out-of-range. Address 3 reads 0. Writes to addresses 1 to 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| cmp_lag | input | 1 | Comparator: returned clock trails, asks for one more tap |
| cmp_lead | input | 1 | Comparator: returned clock leads, asks for one less tap |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| tap_sel_o | output | 7 | Selected delay-line tap |
| ext_range_o | output | 1 | Captured range-extension mode |
| coarse_step_o | output | 1 | Captured coarse-step mode |
| locked_o | output | 1 | Lock flag |

## Verification
The hardest states to reach from the ports are the two ends of the delay line and lock after real dithering, because the tap can only travel one step per five-cycle window. The stimulus holds lag for more than a hundred windows to pin the tap at 127, and holds lead to pin it at 0. A small behavioural comparator in the bench reports lag while the tap sits at or below a target, which drives the loop into a natural two-tap dither. A fixed table of windows covers each pattern of reversals and same-direction runs, checking the tap and the lock flag after every evaluation.

// File: rtl/dll_tap_pkg.sv
package dll_tap_pkg;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DN   = 2'b10
    } step_dir_e;

    typedef struct packed {
        logic coarse;
        logic ext;
        logic park;
    } ctrl_t;

    localparam int unsigned CTRL_PARK_BIT   = 0;
    localparam int unsigned CTRL_EXT_BIT    = 1;
    localparam int unsigned CTRL_COARSE_BIT = 2;
    localparam int unsigned CTRL_USED_W     = 3;

    localparam int unsigned ADDR_CTRL   = 0;
    localparam int unsigned ADDR_TAP    = 1;
    localparam int unsigned ADDR_STATUS = 2;

    localparam int unsigned STAT_LOCK_BIT = 0;
    localparam int unsigned STAT_OOR_BIT  = 1;

    // Conflicting or absent requests mean "hold".
    function automatic step_dir_e decode_dir(input logic lag, input logic lead);
        if (lag && !lead) begin
            return DIR_UP;
        end else if (lead && !lag) begin
            return DIR_DN;
        end
        return DIR_NONE;
    endfunction

endpackage

// File: rtl/dll_cfg_regs.sv
module dll_cfg_regs
    import dll_tap_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned TAP_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [TAP_W-1:0]  tap_i,
    input  logic              lock_i,
    input  logic              oor_i,
    output logic              park_o,
    output logic              armed_o,
    output logic              ext_o,
    output logic              coarse_o,
    output logic              release_o
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  sh_ext;
        logic  sh_coarse;
        logic  armed;
    } cfg_state_t;

    cfg_state_t state_d, state_q;
    logic       wr_ctrl;
    logic       unused_wdata;

    assign unused_wdata = ^wr_data[DATA_W-1:CTRL_USED_W];

    always_comb begin
        state_d   = state_q;
        wr_ctrl   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
        release_o = wr_ctrl && state_q.ctrl.park && !wr_data[CTRL_PARK_BIT];
        if (wr_ctrl) begin
            state_d.ctrl.park   = wr_data[CTRL_PARK_BIT];
            state_d.ctrl.ext    = wr_data[CTRL_EXT_BIT];
            state_d.ctrl.coarse = wr_data[CTRL_COARSE_BIT];
        end
        if (release_o) begin
            state_d.sh_ext    = wr_data[CTRL_EXT_BIT];
            state_d.sh_coarse = wr_data[CTRL_COARSE_BIT];
            state_d.armed     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_W'(ADDR_CTRL): begin
                rd_data[CTRL_PARK_BIT]   = state_q.ctrl.park;
                rd_data[CTRL_EXT_BIT]    = state_q.ctrl.ext;
                rd_data[CTRL_COARSE_BIT] = state_q.ctrl.coarse;
            end
            ADDR_W'(ADDR_TAP): begin
                rd_data[TAP_W-1:0] = tap_i;
            end
            ADDR_W'(ADDR_STATUS): begin
                rd_data[STAT_LOCK_BIT] = lock_i;
                rd_data[STAT_OOR_BIT]  = oor_i;
            end
            default: rd_data = '0;
        endcase
    end

    assign park_o   = state_q.ctrl.park;
    assign armed_o  = state_q.armed;
    assign ext_o    = state_q.sh_ext;
    assign coarse_o = state_q.sh_coarse;

endmodule

// File: rtl/dll_eval_timer.sv
module dll_eval_timer #(
    parameter int unsigned INTERVAL = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);

    localparam int unsigned CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        tick    = !hold && (state_q.cnt == CNT_LAST);
        if (hold || tick) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/dll_tap_step.sv
module dll_tap_step
    import dll_tap_pkg::*;
#(
    parameter int unsigned TAP_COUNT = 128,
    parameter int unsigned PARK_TAP  = 12,
    parameter int unsigned TAP_W     = $clog2(TAP_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  step_dir_e        dir,
    output logic [TAP_W-1:0] tap_o,
    output logic             oor_o
);

    localparam logic [TAP_W-1:0] TAP_MAX  = TAP_W'(TAP_COUNT - 1);
    localparam logic [TAP_W-1:0] TAP_PARK = TAP_W'(PARK_TAP);

    typedef struct packed {
        logic [TAP_W-1:0] tap;
        logic             oor;
    } step_state_t;

    step_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d.tap = TAP_PARK;
            state_d.oor = 1'b0;
        end else if (tick) begin
            unique case (dir)
                DIR_UP: begin
                    if (state_q.tap == TAP_MAX) begin
                        state_d.oor = 1'b1;
                    end else begin
                        state_d.tap = state_q.tap + TAP_W'(1);
                    end
                end
                DIR_DN: begin
                    if (state_q.tap == '0) begin
                        state_d.oor = 1'b1;
                    end else begin
                        state_d.tap = state_q.tap - TAP_W'(1);
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.tap <= TAP_PARK;
            state_q.oor <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tap_o = state_q.tap;
    assign oor_o = state_q.oor;

endmodule

// File: rtl/dll_lock_detect.sv
module dll_lock_detect
    import dll_tap_pkg::*;
#(
    parameter int unsigned REV_TO_LOCK   = 2,
    parameter int unsigned RUN_TO_UNLOCK = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold,
    input  logic      tick,
    input  step_dir_e dir,
    output logic      locked_o
);

    localparam int unsigned REV_W = $clog2(REV_TO_LOCK + 1);
    localparam int unsigned RUN_W = $clog2(RUN_TO_UNLOCK + 1);
    localparam logic [REV_W-1:0] REV_MAX = REV_W'(REV_TO_LOCK);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_TO_UNLOCK);

    typedef struct packed {
        step_dir_e        prev;
        logic [RUN_W-1:0] run;
        logic [REV_W-1:0] rev;
        logic             lock;
    } lock_state_t;

    lock_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d = '0;
        end else if (tick && (dir != DIR_NONE)) begin
            if (state_q.prev == DIR_NONE) begin
                state_d.run = RUN_W'(1);
                state_d.rev = '0;
            end else if (dir == state_q.prev) begin
                state_d.run = (state_q.run == RUN_MAX) ? RUN_MAX : state_q.run + RUN_W'(1);
                state_d.rev = '0;
            end else begin
                state_d.run = RUN_W'(1);
                state_d.rev = (state_q.rev == REV_MAX) ? REV_MAX : state_q.rev + REV_W'(1);
            end
            state_d.prev = dir;
            if (state_d.rev == REV_MAX) begin
                state_d.lock = 1'b1;
            end else if (state_d.run == RUN_MAX) begin
                state_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign locked_o = state_q.lock;

endmodule

// File: rtl/dll_tap_ctrl.sv
module dll_tap_ctrl
    import dll_tap_pkg::*;
#(
    parameter int unsigned TAP_COUNT     = 128,
    parameter int unsigned PARK_TAP      = 12,
    parameter int unsigned INTERVAL      = 5,
    parameter int unsigned REV_TO_LOCK   = 2,
    parameter int unsigned RUN_TO_UNLOCK = 3,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned ADDR_W        = 2,
    localparam int unsigned TAP_W        = $clog2(TAP_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_lag,
    input  logic              cmp_lead,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAP_W-1:0]  tap_sel_o,
    output logic              ext_range_o,
    output logic              coarse_step_o,
    output logic              locked_o
);

    logic      park_w;
    logic      armed_w;
    logic      hold_w;
    logic      eval_tick_w;
    logic      oor_w;
    logic      release_w;
    step_dir_e dir_w;

    assign dir_w  = decode_dir(cmp_lag, cmp_lead);
    assign hold_w = park_w || !armed_w;

    dll_cfg_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .TAP_W  (TAP_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .tap_i     (tap_sel_o),
        .lock_i    (locked_o),
        .oor_i     (oor_w),
        .park_o    (park_w),
        .armed_o   (armed_w),
        .ext_o     (ext_range_o),
        .coarse_o  (coarse_step_o),
        .release_o (release_w)
    );

    dll_eval_timer #(
        .INTERVAL (INTERVAL)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold_w),
        .tick  (eval_tick_w)
    );

    dll_tap_step #(
        .TAP_COUNT (TAP_COUNT),
        .PARK_TAP  (PARK_TAP),
        .TAP_W     (TAP_W)
    ) step_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold_w),
        .tick  (eval_tick_w),
        .dir   (dir_w),
        .tap_o (tap_sel_o),
        .oor_o (oor_w)
    );

    dll_lock_detect #(
        .REV_TO_LOCK   (REV_TO_LOCK),
        .RUN_TO_UNLOCK (RUN_TO_UNLOCK)
    ) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold_w),
        .tick     (eval_tick_w),
        .dir      (dir_w),
        .locked_o (locked_o)
    );

endmodule

// File: rtl/dll_tap_ctrl_chk.sv
module dll_tap_ctrl_chk #(
    parameter int unsigned TAP_COUNT = 128,
    parameter int unsigned PARK_TAP  = 12,
    parameter int unsigned TAP_W     = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_lag,
    input logic             cmp_lead,
    input logic [TAP_W-1:0] tap,
    input logic             locked,
    input logic             ext,
    input logic             coarse,
    input logic             hold,
    input logic             park,
    input logic             armed,
    input logic             tick,
    input logic             oor,
    input logic             rel
);

    localparam logic [TAP_W-1:0] TAP_MAX  = TAP_W'(TAP_COUNT - 1);
    localparam logic [TAP_W-1:0] TAP_PARK = TAP_W'(PARK_TAP);

    assert_unarmed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (tap == TAP_PARK));

    assert_park_forces_R3: assert property (@(posedge clk) disable iff (!rst_n)
        park |=> (tap == TAP_PARK) && !locked && !oor);

    assert_move_only_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !tick) |=> $stable(tap));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (tap == $past(tap)) || (tap == $past(tap) + 1'b1) || ($past(tap) == tap + 1'b1));

    assert_sat_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && tick && cmp_lag && !cmp_lead && tap == TAP_MAX) |=> (tap == TAP_MAX) && oor);

    assert_oor_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oor && !hold) |=> oor);

    assert_mode_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rel |=> $stable(ext) && $stable(coarse));

endmodule

bind dll_tap_ctrl dll_tap_ctrl_chk #(
    .TAP_COUNT (TAP_COUNT),
    .PARK_TAP  (PARK_TAP),
    .TAP_W     (TAP_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_lag  (cmp_lag),
    .cmp_lead (cmp_lead),
    .tap      (tap_sel_o),
    .locked   (locked_o),
    .ext      (ext_range_o),
    .coarse   (coarse_step_o),
    .hold     (hold_w),
    .park     (park_w),
    .armed    (armed_w),
    .tick     (eval_tick_w),
    .oor      (oor_w),
    .rel      (release_w)
);

// File: tb/dll_tap_ctrl_tb_top.sv
module dll_tap_ctrl_tb_top;

    localparam int unsigned CLK_HALF = 2;
    localparam int unsigned NVEC     = 16;

    // Vector fields: [10] lag, [9] lead, [8:2] expected tap, [1] expected lock, [0] expected oor
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 7'd13, 1'b0, 1'b0},
        {1'b1, 1'b0, 7'd14, 1'b0, 1'b0},
        {1'b0, 1'b1, 7'd13, 1'b0, 1'b0},
        {1'b1, 1'b0, 7'd14, 1'b1, 1'b0},
        {1'b0, 1'b0, 7'd14, 1'b1, 1'b0},
        {1'b1, 1'b1, 7'd14, 1'b1, 1'b0},
        {1'b0, 1'b1, 7'd13, 1'b1, 1'b0},
        {1'b0, 1'b1, 7'd12, 1'b1, 1'b0},
        {1'b0, 1'b1, 7'd11, 1'b0, 1'b0},
        {1'b1, 1'b0, 7'd12, 1'b0, 1'b0},
        {1'b0, 1'b1, 7'd11, 1'b1, 1'b0},
        {1'b1, 1'b0, 7'd12, 1'b1, 1'b0},
        {1'b1, 1'b0, 7'd13, 1'b1, 1'b0},
        {1'b1, 1'b0, 7'd14, 1'b0, 1'b0},
        {1'b0, 1'b0, 7'd14, 1'b0, 1'b0},
        {1'b1, 1'b0, 7'd15, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_lag = 1'b0;
    logic       cmp_lead = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [6:0] tap_sel_o;
    logic       ext_range_o;
    logic       coarse_step_o;
    logic       locked_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    dll_tap_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmp_lag       (cmp_lag),
        .cmp_lead      (cmp_lead),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .tap_sel_o     (tap_sel_o),
        .ext_range_o   (ext_range_o),
        .coarse_step_o (coarse_step_o),
        .locked_o      (locked_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks are entered at a falling edge.
    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic arm(input logic coarse, input logic ext);
        write_reg(2'd0, {5'b0, coarse, ext, 1'b1});
        write_reg(2'd0, {5'b0, coarse, ext, 1'b0});
    endtask

    task automatic window(input logic lag, input logic lead);
        cmp_lag = lag; cmp_lead = lead;
        repeat (5) @(negedge clk);
    endtask

    task automatic chk_status(input string req, input int lock_e, input int oor_e);
        logic [7:0] v;
        read_reg(2'd2, v);
        check(req, int'(v[0]), lock_e);
        check(req, int'(v[1]), oor_e);
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 tap", int'(tap_sel_o), 12);
        check("R1 lock", int'(locked_o), 0);
        check("R1 ext", int'(ext_range_o), 0);
        check("R1 coarse", int'(coarse_step_o), 0);
        read_reg(2'd0, v); check("R1 ctrl read", int'(v), 0);
        chk_status("R1 status", 0, 0);

        // R10 read map at reset
        read_reg(2'd1, v); check("R10 tap read", int'(v), 12);
        read_reg(2'd3, v); check("R10 addr3 read", int'(v), 0);

        // R2 no tracking before first release
        window(1'b1, 1'b0);
        window(1'b1, 1'b0);
        check("R2 tap unarmed", int'(tap_sel_o), 12);
        write_reg(2'd0, 8'h06);
        window(1'b1, 1'b0);
        window(1'b1, 1'b0);
        check("R2 tap after non-release write", int'(tap_sel_o), 12);
        check("R9 ext before release", int'(ext_range_o), 0);
        read_reg(2'd0, v); check("R10 ctrl readback", int'(v), 6);

        // R4 timing of first evaluation; R9 capture
        cmp_lag = 1'b0;
        arm(1'b0, 1'b1);
        check("R9 ext captured", int'(ext_range_o), 1);
        check("R9 coarse captured", int'(coarse_step_o), 0);
        cmp_lag = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 no move before 5th edge", int'(tap_sel_o), 12);
        @(negedge clk);
        check("R4 move on 5th edge", int'(tap_sel_o), 13);
        repeat (4) @(negedge clk);
        check("R4 hold between evaluations", int'(tap_sel_o), 13);
        @(negedge clk);
        check("R4 second evaluation", int'(tap_sel_o), 14);

        // R9 write while tracking has no effect on mode outputs
        write_reg(2'd0, 8'h04);
        check("R9 ext held", int'(ext_range_o), 1);
        check("R9 coarse held", int'(coarse_step_o), 0);

        // Table walk: R5 R7 R8
        write_reg(2'd0, 8'h01);
        cmp_lag = 1'b0;
        arm(1'b1, 1'b0);
        check("R9 new capture coarse", int'(coarse_step_o), 1);
        check("R9 new capture ext", int'(ext_range_o), 0);
        for (int i = 0; i < NVEC; i++) begin
            window(VEC[i][10], VEC[i][9]);
            check($sformatf("R5 tap vec %0d", i), int'(tap_sel_o), int'(VEC[i][8:2]));
            check($sformatf("R7/R8 lock vec %0d", i), int'(locked_o), int'(VEC[i][1]));
            read_reg(2'd2, v);
            check($sformatf("R6 oor vec %0d", i), int'(v[1]), int'(VEC[i][0]));
        end

        // R6 saturation at top
        write_reg(2'd0, 8'h01);
        cmp_lag = 1'b0;
        arm(1'b0, 1'b0);
        for (int i = 0; i < 115; i++) window(1'b1, 1'b0);
        check("R6 reach top", int'(tap_sel_o), 127);
        chk_status("R6 no oor at top", 0, 0);
        window(1'b1, 1'b0);
        check("R6 saturate top", int'(tap_sel_o), 127);
        chk_status("R6 oor set", 0, 1);
        window(1'b0, 1'b1);
        check("R6 step down from top", int'(tap_sel_o), 126);
        chk_status("R6 oor sticky", 0, 1);

        // R3 park clears and holds
        write_reg(2'd0, 8'h01);
        cmp_lag = 1'b1;
        repeat (12) @(negedge clk);
        check("R3 park tap", int'(tap_sel_o), 12);
        chk_status("R3 park status", 0, 0);
        write_reg(2'd1, 8'h55);
        read_reg(2'd1, v); check("R10 tap write ignored", int'(v), 12);

        // R6 saturation at bottom
        cmp_lag = 1'b0;
        arm(1'b0, 1'b0);
        for (int i = 0; i < 12; i++) window(1'b0, 1'b1);
        check("R6 reach bottom", int'(tap_sel_o), 0);
        chk_status("R6 no oor at bottom", 0, 0);
        window(1'b0, 1'b1);
        check("R6 saturate bottom", int'(tap_sel_o), 0);
        chk_status("R6 oor bottom", 0, 1);

        // R7 lock via behavioural phase comparator, then R8 unlock
        write_reg(2'd0, 8'h01);
        cmp_lag = 1'b0;
        arm(1'b0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            logic up;
            up = (tap_sel_o <= 7'd40);
            window(up, !up);
        end
        check("R7 dither lock", int'(locked_o), 1);
        check("R7 dither tap", int'((tap_sel_o == 7'd40) || (tap_sel_o == 7'd41)), 1);
        for (int i = 0; i < 3; i++) window(1'b1, 1'b0);
        check("R8 unlock after run", int'(locked_o), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule